// File: doc/BRIEF.md
# BISYNC Receive Character Filter

This block sits after character assembly in a byte-oriented synchronous receiver. Each received 8-bit character comes in with a valid strobe, and the block decides what to do with it. It can drop the character as link fill (idle SYNC, or a DLE escape in transparent mode). It can pass the character on to the receive buffer as data. It can also recognise the character as a block terminator by looking it up in an eight-entry control table.

Each control table entry has two flags. The first says whether block-check bytes follow the terminator. When set, the block lets one check byte (LRC mode) or two check bytes (CRC mode) through to the buffer before it closes the block. The second flag asks the bit-level front end to return to hunt mode once the block is closed. Every close raises an interrupt pulse, which a mask input can suppress. The SYNC and DLE values are programmable, and each has its own enable bit.

Top module: `bsc_rx_filter`

## Requirements
- R1: Outside transparent mode, the first character equal to the SYNC value after reset or after a hunt request is always discarded, and this marks SYN1 as seen.
- R2: Once SYN1 has been seen, outside transparent mode, a character equal to SYNC is discarded when sync_en is 1 and written as data when sync_en is 0.
- R3: In transparent mode with dle_en at 1, a character equal to the DLE value is discarded and marks a DLE as pending. If the character after it is a DLE again, that character is written as data. With dle_en at 0, DLE is ordinary data.
- R4: In transparent mode, a SYNC character that directly follows a stripped DLE is discarded. A SYNC character with no DLE before it is written as data.
- R5: A control table entry matches only when its valid bit is set. Matching applies to every character outside transparent mode, but in transparent mode only to the character right after a stripped DLE. When the matching entry has its check flag clear, the character is written, and buf_close is raised in the same cycle as that write.
- R6: When the matching entry has its check flag set, the character is written and bcs_pending rises. After that, the next two characters (crc_mode=1) or the next one character (crc_mode=0) are written with wr_in_bcs=0 and are never compared with the table. buf_close is raised together with the write of the last of these bytes.
- R7: When the entry that caused a close has its hunt flag set, hunt_req is raised together with that buf_close. When the close waits for check bytes, hunt_req comes with the last check byte. A hunt request clears both the SYN1-seen history and the DLE-pending history.
- R8: Every buf_close comes with a one-cycle irq pulse, unless irq_mask was 1 when the closing character was presented.
- R9: While hunt_mode is 1, input characters produce no write, and both the SYN1-seen history and the DLE-pending history are cleared.
- R10: A character that is accepted shows up on wr_stb/wr_data exactly one clock after its in_valid cycle. wr_in_bcs is 1 for data and for control characters. After reset, every strobe output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Character strobe |
| in_char | input | 8 | Received character |
| hunt_mode | input | 1 | Front end is searching for sync |
| xparent | input | 1 | Transparent mode |
| crc_mode | input | 1 | 1: two check bytes, 0: one check byte |
| sync_char | input | 8 | SYNC value, all 8 bits compared |
| sync_en | input | 1 | Enable SYNC stripping after SYN1 |
| dle_char | input | 8 | DLE value |
| dle_en | input | 1 | Enable DLE stripping |
| irq_mask | input | 1 | Suppress close interrupt |
| ctl_char | input | 64 | Eight table characters, entry k at bits 8k+7:8k |
| ctl_valid | input | 8 | Entry valid bits |
| ctl_bcs | input | 8 | Entry check-bytes-follow flags |
| ctl_hunt | input | 8 | Entry hunt-after-close flags |
| wr_stb | output | 1 | Buffer write strobe |
| wr_data | output | 8 | Buffer write data |
| wr_in_bcs | output | 1 | Character is covered by the block check |
| buf_close | output | 1 | Close the receive buffer |
| hunt_req | output | 1 | Request return to hunt mode |
| bcs_pending | output | 1 | Check bytes are still expected |
| irq | output | 1 | Close interrupt pulse |

## Verification
Three things can happen in the same output cycle: the buffer write of a terminator or of the last check byte, buf_close, and hunt_req. The interrupt pulse can also coincide with them. The bench sets these up with table entries that use every combination of the check and hunt flags, in both LRC and CRC modes, and with the interrupt masked and unmasked. For each write, the scoreboard compares data, the check-coverage flag, close, hunt and irq as one item. Any close, hunt or irq that arrives without a write is counted as a failure.

// File: rtl/bsc_pkg.sv
// Shared types for the BISYNC receive character filter.
// Assumes: one character per in_valid cycle, single clock domain.
package bsc_pkg;
    // What the filter does with the character presented this cycle
    typedef enum logic [1:0] {
        ACT_DROP  = 2'd0,
        ACT_DATA  = 2'd1,
        ACT_CTL   = 2'd2,
        ACT_CHECK = 2'd3
    } bsc_act_e;
endpackage

// File: rtl/bsc_ctl_match.sv
// Compares one character against a table of control characters.
// Assumes: entries with valid clear never match; lowest index wins on ties.
module bsc_ctl_match #(
    parameter int NENT = 8,
    parameter int CHW  = 8
) (
    input  logic [CHW-1:0]      ch,
    input  logic [NENT*CHW-1:0] tbl_char,
    input  logic [NENT-1:0]     tbl_valid,
    input  logic [NENT-1:0]     tbl_bcs,
    input  logic [NENT-1:0]     tbl_hunt,
    output logic                hit,
    output logic                hit_bcs,
    output logic                hit_hunt
);
    logic [NENT-1:0] eq;

    // Per-entry equality, qualified by the entry valid bit
    for (genvar k = 0; k < NENT; k++) begin : g_cmp
        assign eq[k] = tbl_valid[k] && (tbl_char[k*CHW +: CHW] == ch);
    end

    // Priority select of the flags of the lowest matching entry
    always_comb begin
        hit      = 1'b0;
        hit_bcs  = 1'b0;
        hit_hunt = 1'b0;
        for (int k = NENT - 1; k >= 0; k--) begin
            if (eq[k]) begin
                hit      = 1'b1;
                hit_bcs  = tbl_bcs[k];
                hit_hunt = tbl_hunt[k];
            end
        end
    end
endmodule

// File: rtl/bsc_bcs_counter.sv
// Counts the block-check bytes still expected after a terminator.
// Assumes: load and step are never raised together.
module bsc_bcs_counter #(
    parameter int CRC_BYTES = 2,
    parameter int LRC_BYTES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic load_crc,
    input  logic step,
    output logic pending,
    output logic last
);
    localparam int CW = $clog2(CRC_BYTES + 1);
    logic [CW-1:0] cnt;

    // Load the byte count on a terminator, count down per check byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_crc ? CW'(CRC_BYTES) : CW'(LRC_BYTES);
        end else if (step && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign pending = (cnt != '0);
    assign last    = (cnt == CW'(1));
endmodule

// File: rtl/bsc_rx_filter.sv
// BISYNC receive character filter: strips SYNC/DLE fill characters,
// detects table terminators, counts block-check bytes and drives the
// buffer write/close, hunt request and interrupt strobes.
// Assumes: outputs are registered, one cycle after the input character.
module bsc_rx_filter #(
    parameter int CHW  = 8,
    parameter int NENT = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [CHW-1:0]      in_char,
    input  logic                hunt_mode,
    input  logic                xparent,
    input  logic                crc_mode,
    input  logic [CHW-1:0]      sync_char,
    input  logic                sync_en,
    input  logic [CHW-1:0]      dle_char,
    input  logic                dle_en,
    input  logic                irq_mask,
    input  logic [NENT*CHW-1:0] ctl_char,
    input  logic [NENT-1:0]     ctl_valid,
    input  logic [NENT-1:0]     ctl_bcs,
    input  logic [NENT-1:0]     ctl_hunt,
    output logic                wr_stb,
    output logic [CHW-1:0]      wr_data,
    output logic                wr_in_bcs,
    output logic                buf_close,
    output logic                hunt_req,
    output logic                bcs_pending,
    output logic                irq
);
    import bsc_pkg::*;

    logic     hit, hit_bcs, hit_hunt;
    logic     cnt_last;
    logic     syn_seen, syn_nxt;
    logic     dle_pend, dle_nxt;
    logic     held_hunt;
    logic     is_sync, is_dle;
    logic     close_now, hunt_now;
    bsc_act_e act;

    bsc_ctl_match #(.NENT(NENT), .CHW(CHW)) u_match (
        .ch        (in_char),
        .tbl_char  (ctl_char),
        .tbl_valid (ctl_valid),
        .tbl_bcs   (ctl_bcs),
        .tbl_hunt  (ctl_hunt),
        .hit       (hit),
        .hit_bcs   (hit_bcs),
        .hit_hunt  (hit_hunt)
    );

    bsc_bcs_counter u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (act == ACT_CTL && hit_bcs),
        .load_crc (crc_mode),
        .step     (act == ACT_CHECK),
        .pending  (bcs_pending),
        .last     (cnt_last)
    );

    assign is_sync = (in_char == sync_char);
    assign is_dle  = (in_char == dle_char);

    // Classify the incoming character and update stripping history
    always_comb begin
        act     = ACT_DROP;
        syn_nxt = syn_seen;
        dle_nxt = dle_pend;
        if (in_valid && !hunt_mode) begin
            if (bcs_pending) begin
                act = ACT_CHECK;
            end else if (xparent) begin
                if (dle_pend) begin
                    dle_nxt = 1'b0;
                    if (is_sync)  act = ACT_DROP;
                    else if (hit) act = ACT_CTL;
                    else          act = ACT_DATA;
                end else if (dle_en && is_dle) begin
                    dle_nxt = 1'b1;
                    act     = ACT_DROP;
                end else begin
                    act = ACT_DATA;
                end
            end else begin
                if (is_sync && !syn_seen) begin
                    syn_nxt = 1'b1;
                    act     = ACT_DROP;
                end else if (is_sync && sync_en) begin
                    act = ACT_DROP;
                end else if (hit) begin
                    act = ACT_CTL;
                end else begin
                    act = ACT_DATA;
                end
            end
        end
        close_now = (act == ACT_CTL && !hit_bcs) || (act == ACT_CHECK && cnt_last);
        hunt_now  = (act == ACT_CTL && !hit_bcs && hit_hunt) ||
                    (act == ACT_CHECK && cnt_last && held_hunt);
        if (hunt_mode || hunt_now) begin
            syn_nxt = 1'b0;
            dle_nxt = 1'b0;
        end
    end

    // Stripping history and the hunt flag held across check bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            syn_seen  <= 1'b0;
            dle_pend  <= 1'b0;
            held_hunt <= 1'b0;
        end else begin
            syn_seen <= syn_nxt;
            dle_pend <= dle_nxt;
            if (act == ACT_CTL && hit_bcs) held_hunt <= hit_hunt;
        end
    end

    // Registered buffer and event strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_stb    <= 1'b0;
            wr_data   <= '0;
            wr_in_bcs <= 1'b0;
            buf_close <= 1'b0;
            hunt_req  <= 1'b0;
            irq       <= 1'b0;
        end else begin
            wr_stb    <= (act != ACT_DROP);
            wr_data   <= (act != ACT_DROP) ? in_char : wr_data;
            wr_in_bcs <= (act == ACT_DATA) || (act == ACT_CTL);
            buf_close <= close_now;
            hunt_req  <= hunt_now;
            irq       <= close_now && !irq_mask;
        end
    end
endmodule

// File: rtl/bsc_rx_filter_chk.sv
// Property checker for bsc_rx_filter, attached with bind.
// Assumes: port names match the top module's port names.
module bsc_rx_filter_chk (
    input logic clk,
    input logic rst_n,
    input logic hunt_mode,
    input logic irq_mask,
    input logic wr_stb,
    input logic wr_in_bcs,
    input logic buf_close,
    input logic hunt_req,
    input logic bcs_pending,
    input logic irq
);
    // R5
    close_has_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_close |-> wr_stb);
    // R6
    check_byte_while_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !wr_in_bcs) |-> $past(bcs_pending));
    // R6
    pending_starts_on_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bcs_pending) |-> (wr_stb && wr_in_bcs && !buf_close));
    // R7
    hunt_with_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hunt_req |-> buf_close);
    // R8
    irq_follows_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_close |-> (irq == !$past(irq_mask)));
    // R8
    irq_only_on_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> buf_close);
    // R9
    no_write_in_hunt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(hunt_mode) |-> !wr_stb);
endmodule

bind bsc_rx_filter bsc_rx_filter_chk u_chk (.*);

// File: tb/bsc_rx_filter_tb.sv
module bsc_rx_filter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_char = '0;
    logic        hunt_mode = 1'b0, xparent = 1'b0, crc_mode = 1'b1;
    logic [7:0]  sync_char = 8'h32, dle_char = 8'h10;
    logic        sync_en = 1'b1, dle_en = 1'b1, irq_mask = 1'b0;
    logic [63:0] ctl_char;
    logic [7:0]  ctl_valid, ctl_bcs, ctl_hunt;
    logic        wr_stb, wr_in_bcs, buf_close, hunt_req, bcs_pending, irq;
    logic [7:0]  wr_data;

    typedef struct packed {
        logic [7:0] d;
        logic       b;
        logic       c;
        logic       h;
        logic       i;
    } exp_t;

    exp_t  q[$];
    string tq[$];
    int    checks = 0;
    int    fails  = 0;
    bit    done   = 1'b0;

    always #10 clk = ~clk;

    bsc_rx_filter u_dut (.*);

    // Table: ETX(B,H) ETB(B) ENQ() EOT(H) 0x55 invalid, rest invalid
    initial begin
        ctl_char  = {8'h00, 8'h00, 8'h00, 8'h55, 8'h37, 8'h2D, 8'h26, 8'h03};
        ctl_valid = 8'b0000_1111;
        ctl_bcs   = 8'b0001_0011;
        ctl_hunt  = 8'b0001_1001;
    end

    task automatic send(input logic [7:0] c, input bit wr, input bit b,
                        input bit cl, input bit h, input bit i, input string tag);
        @(negedge clk);
        in_char  = c;
        in_valid = 1'b1;
        if (wr) begin
            q.push_back('{d: c, b: b, c: cl, h: h, i: i});
            tq.push_back(tag);
        end
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic check_bit(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Scoreboard monitor: pops one expected item per buffer write
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (wr_stb) begin
                checks++;
                if (q.size() == 0) begin
                    fails++;
                    $display("FAIL R10 unexpected write actual=%h expected=none", wr_data);
                end else begin
                    exp_t  e;
                    string t;
                    e = q.pop_front();
                    t = tq.pop_front();
                    if ({wr_data, wr_in_bcs, buf_close, hunt_req, irq} !== e) begin
                        fails++;
                        $display("FAIL %s actual=%h/%b%b%b%b expected=%h/%b%b%b%b", t,
                                 wr_data, wr_in_bcs, buf_close, hunt_req, irq,
                                 e.d, e.b, e.c, e.h, e.i);
                    end
                end
            end else if (buf_close || hunt_req || irq) begin
                checks++;
                fails++;
                $display("FAIL R5 event without write actual=%b%b%b expected=000",
                         buf_close, hunt_req, irq);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check_bit(wr_stb | buf_close | hunt_req | irq | bcs_pending, 1'b0, "R10 reset state");
        rst_n = 1'b1;
        @(negedge clk);

        // Normal mode, CRC
        send(8'h32, 0, 0, 0, 0, 0, "R1 SYN1 strip");
        send(8'h32, 0, 0, 0, 0, 0, "R2 SYNC strip");
        send(8'h41, 1, 1, 0, 0, 0, "R10 data");
        send(8'h55, 1, 1, 0, 0, 0, "R5 invalid entry is data");
        send(8'h26, 1, 1, 0, 0, 0, "R6 ETB write");
        check_bit(bcs_pending, 1'b1, "R6 pending after ETB");
        send(8'hAA, 1, 0, 0, 0, 0, "R6 check byte 1");
        send(8'h03, 1, 0, 1, 0, 1, "R6 check byte 2 not matched");
        check_bit(bcs_pending, 1'b0, "R6 pending cleared");

        // Immediate close, masked irq
        irq_mask = 1'b1;
        send(8'h2D, 1, 1, 1, 0, 0, "R8 masked close");
        irq_mask = 1'b0;
        send(8'h2D, 1, 1, 1, 0, 1, "R5 immediate close");

        // Hunt on close, history reset, SYNC valid bit
        send(8'h37, 1, 1, 1, 1, 1, "R7 hunt close");
        send(8'h32, 0, 0, 0, 0, 0, "R7 SYN1 strip after hunt");
        sync_en = 1'b0;
        send(8'h32, 1, 1, 0, 0, 0, "R2 SYNC kept when disabled");
        sync_en = 1'b1;

        // LRC mode with hunt after check byte
        crc_mode = 1'b0;
        send(8'h03, 1, 1, 0, 0, 0, "R6 ETX write");
        send(8'h77, 1, 0, 1, 1, 1, "R7 LRC close with hunt");
        crc_mode = 1'b1;

        // Hunt mode input drops characters
        hunt_mode = 1'b1;
        send(8'h41, 0, 0, 0, 0, 0, "R9 dropped in hunt");
        hunt_mode = 1'b0;

        // Transparent mode
        xparent = 1'b1;
        send(8'h32, 1, 1, 0, 0, 0, "R4 bare SYNC is data");
        send(8'h10, 0, 0, 0, 0, 0, "R3 DLE strip");
        send(8'h32, 0, 0, 0, 0, 0, "R4 DLE SYNC strip");
        send(8'h10, 0, 0, 0, 0, 0, "R3 DLE strip");
        send(8'h10, 1, 1, 0, 0, 0, "R3 DLE DLE data");
        send(8'h2D, 1, 1, 0, 0, 0, "R5 bare control is data");
        send(8'h10, 0, 0, 0, 0, 0, "R3 DLE strip");
        send(8'h2D, 1, 1, 1, 0, 1, "R5 DLE ENQ close");
        dle_en = 1'b0;
        send(8'h10, 1, 1, 0, 0, 0, "R3 DLE kept when disabled");
        dle_en = 1'b1;
        send(8'h10, 0, 0, 0, 0, 0, "R3 DLE strip");
        hunt_mode = 1'b1;
        @(negedge clk);
        hunt_mode = 1'b0;
        send(8'h32, 1, 1, 0, 0, 0, "R9 DLE history cleared");

        repeat (4) @(negedge clk);
        check_bit(q.size() == 0, 1'b1, "R10 all expected writes seen");
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule